// File: doc/BRIEF.md
# Serial Transceiver Reset Sequencer

This block is a synchronous controller that owns the four reset lines of a serial transceiver channel carrying a PCIe Gen1 style link: the reset of the transmit PLL, the transmit digital reset, the receive analog reset and the receive digital reset. After a power-on hold it brings the channel up in an initialization/compliance phase. In that phase, receive analog and digital resets drop together once the PLL has locked and the reconfiguration logic has gone quiet. A done strobe from the link layer then moves it into the normal phase.

In the normal phase the sequencer watches the receive frequency-lock flags. When lock is lost it waits for every lane to lock again. It then lets a parameterized lock-time delay expire and gives the receive digital reset one two-clock pulse, which initializes the receive phase-compensation FIFO. Bonded configurations of two or four lanes require every lane's flag before the delay starts. Loss of PLL lock at any point after bring-up sends the sequencer back to its power-on state. All status inputs are taken as already synchronous to the sequencer clock, which is also the channel's parallel clock. Every reset output comes straight from a flop.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst_n` is low and for exactly `POR_CYCLES` clocks after it is released, `pll_rst_o`, `tx_dig_rst_o`, `rx_ana_rst_o` and `rx_dig_rst_o` are all 1 and `normal_phase_o` is 0.
- R2: After the power-on hold, `tx_dig_rst_o` stays 1 until `pll_locked_i` is sampled high, and falls on the clock after that sample.
- R3: `rx_ana_rst_o` falls only after `reconfig_busy_i` has been sampled low on two consecutive clocks following the PLL lock. A return of busy during that wait starts the wait over.
- R4: In the compliance phase (`normal_phase_o` = 0), `rx_dig_rst_o` equals `rx_ana_rst_o` on every cycle, and the frequency-lock inputs have no effect on any output.
- R5: `normal_phase_o` rises only on the clock after `link_done_i` is sampled high while the receive resets are released in the compliance phase. A done strobe seen earlier is ignored.
- R6: In the normal phase, while any lane's frequency-lock input is low, `rx_dig_rst_o` is not asserted.
- R7: In the normal phase, after all lock inputs have been high for `LOCK_WAIT_CYCLES` consecutive clocks, `rx_dig_rst_o` is 1 for exactly 2 clocks and then returns to 0. A lock drop during the pulse does not shorten it.
- R8: With `NUM_LANES` of 2 or 4, the lock-time count starts only when every lane's bit of `rx_freq_lock_i` is 1. A drop of any single lane during the count restarts the wait for all lanes.
- R9: If `pll_locked_i` is sampled low once the transmit reset has been released, on the next clock all four reset outputs are 1 and `normal_phase_o` is 0, and a full power-on hold follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, equal to the channel parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| pll_locked_i | input | 1 | Transmit PLL lock status |
| reconfig_busy_i | input | 1 | Reconfiguration logic busy flag |
| rx_freq_lock_i | input | NUM_LANES | Per-lane receive frequency-lock flags |
| link_done_i | input | 1 | Link layer reports the compliance phase finished |
| pll_rst_o | output | 1 | Reset to the transmit PLL |
| tx_dig_rst_o | output | 1 | Transmit digital reset |
| rx_ana_rst_o | output | 1 | Receive analog reset |
| rx_dig_rst_o | output | 1 | Receive digital reset |
| normal_phase_o | output | 1 | 0 in initialization/compliance phase, 1 in normal phase |

## Verification
The bench counts the power-on hold to the exact clock, so a timer that is off by one in either direction shows up as an early or late PLL reset release. It drops the busy flag, raises it again and drops it once more to catch a settle counter that does not restart. It also toggles lane locks in the compliance phase, where a design that wrongly keys on frequency lock would move the digital reset. In the normal phase a table drives single-lane drops during the lock-time count and during the pulse. A design that ANDs the lanes wrongly, fails to restart the count or cuts the pulse short gives a digital reset that appears early, late or with the wrong width.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

   // Sequencer states, ordered by bring-up progress
   typedef enum logic [3:0] {
      ST_POR       = 4'd0,   // power-on hold, PLL in reset
      ST_PLL_WAIT  = 4'd1,   // PLL released, waiting for lock
      ST_BUSY_WAIT = 4'd2,   // transmit up, waiting for reconfig idle
      ST_SETTLE    = 4'd3,   // reconfig idle, counting settle clocks
      ST_COMPLY    = 4'd4,   // compliance phase, receive released
      ST_NORMAL    = 4'd5,   // normal phase, all lanes locked
      ST_RELOCK    = 4'd6,   // normal phase, waiting for lane lock
      ST_LOCK_DLY  = 4'd7,   // normal phase, lock-time delay
      ST_DIG_PULSE = 4'd8    // normal phase, receive digital pulse
   } seq_state_e;

   typedef struct packed {
      logic pll_rst;
      logic tx_dig;
      logic rx_ana;
      logic rx_dig;
      logic normal;
   } rst_vec_t;

   // Reset levels that each state presents at the outputs
   function automatic rst_vec_t state_levels(input seq_state_e st);
      rst_vec_t v;
      v = '{pll_rst: 1'b1, tx_dig: 1'b1, rx_ana: 1'b1, rx_dig: 1'b1, normal: 1'b0};
      case (st)
         ST_POR:       v = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
         ST_PLL_WAIT:  v = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
         ST_BUSY_WAIT: v = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
         ST_SETTLE:    v = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
         ST_COMPLY:    v = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
         ST_NORMAL:    v = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
         ST_RELOCK:    v = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
         ST_LOCK_DLY:  v = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
         ST_DIG_PULSE: v = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
         default:      v = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
      endcase
      return v;
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/xrs_timer.sv
module xrs_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   // Counts clocks spent in the current state, saturating at the top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_TOP) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/xrs_lock_merge.sv
module xrs_lock_merge #(
   parameter int NUM_LANES = 1
) (
   input  logic [NUM_LANES-1:0] lock_i,
   output logic                 all_o
);

   generate
      if (NUM_LANES == 1) begin : g_single
         assign all_o = lock_i[0];
      end else begin : g_bonded
         logic [NUM_LANES-1:0] chain;
         assign chain[0] = lock_i[0];
         for (genvar g = 1; g < NUM_LANES; g++) begin : g_and
            assign chain[g] = chain[g-1] & lock_i[g];
         end
         assign all_o = chain[NUM_LANES-1];
      end
   endgenerate

endmodule

// File: rtl/xrs_fsm.sv
module xrs_fsm
   import xrs_pkg::*;
#(
   parameter int POR_CYCLES       = 50,
   parameter int SETTLE_CYCLES    = 2,
   parameter int LOCK_WAIT_CYCLES = 200,
   parameter int PULSE_CYCLES     = 2,
   parameter int CNT_W            = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pll_locked_i,
   input  logic             busy_i,
   input  logic             all_lock_i,
   input  logic             done_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             cnt_clr_o,
   output rst_vec_t         rst_o
);

   localparam logic [CNT_W-1:0] POR_LAST    = CNT_W'(POR_CYCLES - 1);
   localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
   localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_WAIT_CYCLES - 1);
   localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYCLES - 1);

   seq_state_e state_q, state_d;
   rst_vec_t   rst_q;
   logic       pll_watch;

   // PLL lock is watched once the PLL has been released and has locked
   assign pll_watch = (state_q != ST_POR) && (state_q != ST_PLL_WAIT);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_POR: begin
            if (cnt_i == POR_LAST) state_d = ST_PLL_WAIT;
         end
         ST_PLL_WAIT: begin
            if (pll_locked_i) state_d = ST_BUSY_WAIT;
         end
         ST_BUSY_WAIT: begin
            if (!busy_i) state_d = ST_SETTLE;
         end
         ST_SETTLE: begin
            if (busy_i) begin
               state_d = ST_BUSY_WAIT;
            end else if (cnt_i == SETTLE_LAST) begin
               state_d = ST_COMPLY;
            end
         end
         ST_COMPLY: begin
            if (done_i) state_d = ST_NORMAL;
         end
         ST_NORMAL: begin
            if (!all_lock_i) state_d = ST_RELOCK;
         end
         ST_RELOCK: begin
            if (all_lock_i) state_d = ST_LOCK_DLY;
         end
         ST_LOCK_DLY: begin
            if (!all_lock_i) begin
               state_d = ST_RELOCK;
            end else if (cnt_i == LOCK_LAST) begin
               state_d = ST_DIG_PULSE;
            end
         end
         ST_DIG_PULSE: begin
            if (cnt_i == PULSE_LAST) state_d = ST_NORMAL;
         end
         default: state_d = ST_POR;
      endcase
      if (pll_watch && !pll_locked_i) begin
         state_d = ST_POR;
      end
   end

   assign cnt_clr_o = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_POR;
         rst_q   <= state_levels(ST_POR);
      end else begin
         state_q <= state_d;
         rst_q   <= state_levels(state_d);
      end
   end

   assign rst_o = rst_q;

endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
   import xrs_pkg::*;
#(
   parameter int NUM_LANES        = 1,
   parameter int POR_CYCLES       = 50,
   parameter int SETTLE_CYCLES    = 2,
   parameter int LOCK_WAIT_CYCLES = 200,
   parameter int PULSE_CYCLES     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pll_locked_i,
   input  logic                 reconfig_busy_i,
   input  logic [NUM_LANES-1:0] rx_freq_lock_i,
   input  logic                 link_done_i,
   output logic                 pll_rst_o,
   output logic                 tx_dig_rst_o,
   output logic                 rx_ana_rst_o,
   output logic                 rx_dig_rst_o,
   output logic                 normal_phase_o
);

   localparam int MAX_CNT = max4(POR_CYCLES, SETTLE_CYCLES, LOCK_WAIT_CYCLES, PULSE_CYCLES);
   localparam int CNT_W   = $clog2(MAX_CNT + 1);

   generate
      if (NUM_LANES != 1 && NUM_LANES != 2 && NUM_LANES != 4) begin : g_bad_lanes
         $error("xcvr_rst_seq: NUM_LANES must be 1, 2 or 4");
      end
      if (POR_CYCLES < 2) begin : g_bad_por
         $error("xcvr_rst_seq: POR_CYCLES must be at least 2");
      end
      if (SETTLE_CYCLES < 1 || LOCK_WAIT_CYCLES < 1 || PULSE_CYCLES < 1) begin : g_bad_cnt
         $error("xcvr_rst_seq: settle, lock-wait and pulse counts must be at least 1");
      end
   endgenerate

   logic             all_lock;
   logic             cnt_clr;
   logic [CNT_W-1:0] cnt;
   rst_vec_t         rst_vec;

   xrs_lock_merge #(
      .NUM_LANES (NUM_LANES)
   ) lock_merge_i (
      .lock_i (rx_freq_lock_i),
      .all_o  (all_lock)
   );

   xrs_timer #(
      .CNT_W (CNT_W)
   ) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .cnt_o (cnt)
   );

   xrs_fsm #(
      .POR_CYCLES       (POR_CYCLES),
      .SETTLE_CYCLES    (SETTLE_CYCLES),
      .LOCK_WAIT_CYCLES (LOCK_WAIT_CYCLES),
      .PULSE_CYCLES     (PULSE_CYCLES),
      .CNT_W            (CNT_W)
   ) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .pll_locked_i (pll_locked_i),
      .busy_i       (reconfig_busy_i),
      .all_lock_i   (all_lock),
      .done_i       (link_done_i),
      .cnt_i        (cnt),
      .cnt_clr_o    (cnt_clr),
      .rst_o        (rst_vec)
   );

   assign pll_rst_o      = rst_vec.pll_rst;
   assign tx_dig_rst_o   = rst_vec.tx_dig;
   assign rx_ana_rst_o   = rst_vec.rx_ana;
   assign rx_dig_rst_o   = rst_vec.rx_dig;
   assign normal_phase_o = rst_vec.normal;

endmodule

// File: rtl/xrs_checker.sv
module xrs_checker #(
   parameter int NUM_LANES = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pll_locked_i,
   input logic                 reconfig_busy_i,
   input logic [NUM_LANES-1:0] rx_freq_lock_i,
   input logic                 link_done_i,
   input logic                 pll_rst_o,
   input logic                 tx_dig_rst_o,
   input logic                 rx_ana_rst_o,
   input logic                 rx_dig_rst_o,
   input logic                 normal_phase_o
);

   AST_POR_HOLDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      pll_rst_o |-> (tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o && !normal_phase_o)); // R1

   AST_TX_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_dig_rst_o) |-> $past(pll_locked_i)); // R2

   AST_ANA_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_ana_rst_o) |-> (!$past(reconfig_busy_i) && !$past(reconfig_busy_i, 2))); // R3

   AST_COMPLY_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      !normal_phase_o |-> (rx_dig_rst_o == rx_ana_rst_o)); // R4

   AST_PHASE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(normal_phase_o) |-> $past(link_done_i)); // R5

   AST_NO_PULSE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (normal_phase_o && !(&rx_freq_lock_i) && !rx_dig_rst_o) |=> !rx_dig_rst_o); // R6

   AST_PULSE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_dig_rst_o) && normal_phase_o) |=> (rx_dig_rst_o || !normal_phase_o)); // R7

   AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_dig_rst_o) && normal_phase_o) |=> ##1 (!rx_dig_rst_o || !normal_phase_o)); // R7

   AST_PULSE_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_dig_rst_o) && normal_phase_o) |-> (&$past(rx_freq_lock_i))); // R8

   AST_PLL_LOSS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_dig_rst_o && !pll_locked_i) |=> (pll_rst_o && !normal_phase_o)); // R9

endmodule

bind xcvr_rst_seq xrs_checker #(
   .NUM_LANES (NUM_LANES)
) xrs_checker_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .pll_locked_i    (pll_locked_i),
   .reconfig_busy_i (reconfig_busy_i),
   .rx_freq_lock_i  (rx_freq_lock_i),
   .link_done_i     (link_done_i),
   .pll_rst_o       (pll_rst_o),
   .tx_dig_rst_o    (tx_dig_rst_o),
   .rx_ana_rst_o    (rx_ana_rst_o),
   .rx_dig_rst_o    (rx_dig_rst_o),
   .normal_phase_o  (normal_phase_o)
);

// File: tb/xcvr_rst_seq_tb_top.sv
`timescale 1ns/1ps
module xcvr_rst_seq_tb_top;

   localparam int LANES  = 2;
   localparam int POR_N  = 8;
   localparam int LOCK_N = 3;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             pll_locked;
   logic             busy;
   logic [LANES-1:0] lanes;
   logic             done;
   logic             pll_rst, tx_rst, ana_rst, dig_rst, normal;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   xcvr_rst_seq #(
      .NUM_LANES        (LANES),
      .POR_CYCLES       (POR_N),
      .SETTLE_CYCLES    (2),
      .LOCK_WAIT_CYCLES (LOCK_N),
      .PULSE_CYCLES     (2)
   ) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .pll_locked_i    (pll_locked),
      .reconfig_busy_i (busy),
      .rx_freq_lock_i  (lanes),
      .link_done_i     (done),
      .pll_rst_o       (pll_rst),
      .tx_dig_rst_o    (tx_rst),
      .rx_ana_rst_o    (ana_rst),
      .rx_dig_rst_o    (dig_rst),
      .normal_phase_o  (normal)
   );

   // Normal-phase lock table: {lane1, lane0, expected rx_dig_rst}, one row per clock
   localparam logic [2:0] LOCK_TBL [21] = '{
      3'b010, 3'b010, 3'b110, 3'b110, 3'b100, 3'b110, 3'b110, 3'b110,
      3'b111, 3'b111, 3'b110, 3'b110, 3'b000, 3'b110, 3'b110, 3'b110,
      3'b111, 3'b011, 3'b010, 3'b010, 3'b110
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic [4:0] exp);
      chk(req, "pll_rst", pll_rst, exp[4]);
      chk(req, "tx_dig_rst", tx_rst, exp[3]);
      chk(req, "rx_ana_rst", ana_rst, exp[2]);
      chk(req, "rx_dig_rst", dig_rst, exp[1]);
      chk(req, "normal_phase", normal, exp[0]);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; pll_locked = 1'b0; busy = 1'b1; lanes = '1; done = 1'b0;
      repeat (3) @(negedge clk);
      chk_all("R1", 5'b11110);            // reset state

      rst_n = 1'b1;
      for (int k = 1; k < POR_N; k++) begin
         step();
         chk_all("R1", 5'b11110);         // power-on hold
      end
      step();
      chk("R1", "pll_rst end of hold", pll_rst, 1'b0);
      chk("R2", "tx_dig_rst before lock", tx_rst, 1'b1);

      done = 1'b1;                        // early done must be ignored
      repeat (3) begin
         step();
         chk("R2", "tx_dig_rst no lock", tx_rst, 1'b1);
         chk("R5", "normal_phase early done", normal, 1'b0);
      end
      done = 1'b0;

      pll_locked = 1'b1;
      step();
      chk("R2", "tx_dig_rst after lock", tx_rst, 1'b0);
      chk("R3", "rx_ana_rst busy", ana_rst, 1'b1);
      repeat (3) begin
         step();
         chk("R3", "rx_ana_rst busy held", ana_rst, 1'b1);
      end

      busy = 1'b0;
      step();
      chk("R3", "rx_ana_rst settle 1", ana_rst, 1'b1);
      busy = 1'b1;                        // glitch restarts the settle wait
      step();
      chk("R3", "rx_ana_rst busy return", ana_rst, 1'b1);
      busy = 1'b0;
      step();
      chk("R3", "rx_ana_rst restart a", ana_rst, 1'b1);
      step();
      chk("R3", "rx_ana_rst restart b", ana_rst, 1'b1);
      step();
      chk("R3", "rx_ana_rst released", ana_rst, 1'b0);
      chk("R4", "rx_dig_rst with analog", dig_rst, 1'b0);
      chk("R4", "normal_phase compliance", normal, 1'b0);

      lanes = '0;                         // lock has no effect in compliance
      repeat (3) begin
         step();
         chk_all("R4", 5'b00000);
      end
      lanes = '1;
      step();
      chk_all("R4", 5'b00000);

      done = 1'b1;
      step();
      chk("R5", "normal_phase on done", normal, 1'b1);
      done = 1'b0;

      for (int i = 0; i < 21; i++) begin
         lanes = LOCK_TBL[i][2:1];
         step();
         chk((i == 4 || i == 17) ? "R8" : (LOCK_TBL[i][0] ? "R7" : "R6"),
             $sformatf("rx_dig_rst row %0d", i), dig_rst, LOCK_TBL[i][0]);
         chk("R6", $sformatf("normal_phase row %0d", i), normal, 1'b1);
      end
      lanes = '1;
      repeat (6) step();
      chk_all("R7", 5'b00001);

      pll_locked = 1'b0;
      step();
      chk_all("R9", 5'b11110);
      pll_locked = 1'b1;
      repeat (POR_N - 2) step();
      chk("R9", "pll_rst full hold", pll_rst, 1'b1);
      step();
      step();
      chk("R9", "pll_rst hold end", pll_rst, 1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule